// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level tree of translation tables held in ordinary memory. A request carries the virtual address and two access attributes: whether it is a write and whether it comes from user mode. The walker reads one first-level entry and then one second-level entry through a word-wide memory port that uses valid/ready handshakes. It checks presence, format, privilege and write permission at each level. It then answers with either the physical address or a fault that carries a cause code and the level where the walk stopped.

Each table fills exactly one 4 KB page with 1024 four-byte entries. The tree's root is given as a frame number on `root_frame`, which is the only value that changes on a context switch. After a successful walk, the walker writes the accessed flag back into each entry that lacks it. On a write it also writes the dirty flag into the leaf entry. Each entry is written at most once, and only if its value actually changes. A write to a page without write permission raises a write-protect fault. Software uses this fault to find shared copy-on-write pages.

Entry format, as the walker uses it: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, bit 7 large page (meaningful in first-level entries only), bits 31:12 frame number. Bits 3, 4 and 8 to 11 pass through unchanged.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. The address, the access attributes and `root_frame` are captured at that edge, so later changes to them do not affect the walk in progress.
- R2: The first memory read is a read (`mem_req_we`=0) of byte address `{root_frame, 12'b0} + vaddr[31:22]*4`.
- R3: The second memory read goes to `{L1 entry[31:12], 12'b0} + vaddr[21:12]*4`.
- R4: A memory request holds its address, write enable and data stable until `mem_req_ready` is seen. At most one read is outstanding at a time. A walk that reaches the second level issues exactly two reads.
- R5: On success, `rsp_fault`=0 and `rsp_paddr` = `{L2 entry[31:12], vaddr[11:0]}`.
- R6: An entry with bit 0 clear stops the walk with cause 0 (not present) at that level, whatever its other bits hold. A not-present first-level entry causes no second read.
- R7: A present first-level entry with bit 7 set gives cause 3 (unsupported large page) at level 1. Bit 7 has no effect in a second-level entry.
- R8: A user access (`req_user`=1) to an entry with bit 2 clear, at either level, gives cause 2 (privilege). Supervisor accesses ignore bit 2.
- R9: A write (`req_write`=1) to an entry with bit 1 clear, at either level, gives cause 1 (write protect). Reads ignore bit 1. At one level the checks rank not-present, then large page, then privilege, then write protect.
- R10: After a successful walk, the first-level entry is rewritten with bit 5 set if bit 5 was clear. The second-level entry is then rewritten with bit 5 set, and with bit 6 also set for a write, if that changes it. All other bits are kept. A faulting walk writes nothing.
- R11: The result is a one-cycle pulse on `rsp_valid`. It carries `rsp_cause` (0 to 3 as above), `rsp_level` (0 for first level, 1 for second level) and `rsp_vaddr`, which is the virtual address of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| root_frame | input | 20 | Frame number of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry value for write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Entry value read |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | Fault cause code |
| rsp_level | output | 1 | Level of the faulting entry |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_vaddr | output | 32 | Virtual address of the request |

## Verification
The bench builds the walker with its default split of 10/10/12 bits and 32-bit entries. This puts the real 4 KB table geometry within reach, including index 1023 at both levels, where the entry address touches the last word of a table page. With memory modelled as a sparse map, one root table can hold entries for every fault kind at once. A second root frame checks that a context switch is just a new frame number. A mode that drops `mem_req_ready` on alternate cycles drives the request-hold rule and the walk-back ordering under back-pressure.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_L1_RD,
        S_L1_WT,
        S_L1_CK,
        S_L2_RD,
        S_L2_WT,
        S_L2_CK,
        S_WB1,
        S_WB2,
        S_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        CAUSE_ABSENT = 2'd0,
        CAUSE_WPROT  = 2'd1,
        CAUSE_PRIV   = 2'd2,
        CAUSE_HUGE   = 2'd3
    } fault_cause_e;

    // entry flag positions
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_ACC     = 5;
    localparam int BIT_DIRTY   = 6;
    localparam int BIT_HUGE    = 7;

    // the flags the permission checker looks at
    typedef struct packed {
        logic present;
        logic writable;
        logic user_ok;
        logic huge;
    } pte_flags_t;

endpackage

// File: rtl/ptw_entry_check.sv
`timescale 1ns/1ps
module ptw_entry_check
    import ptw_pkg::*;
(
    input  pte_flags_t   flags,
    input  logic         first_lvl,
    input  logic         acc_write,
    input  logic         acc_user,
    output logic         fault,
    output fault_cause_e cause
);

    // presence is looked at before anything else; the other flags mean
    // nothing in an absent entry
    always_comb begin
        fault = 1'b0;
        cause = CAUSE_ABSENT;
        if (!flags.present) begin
            fault = 1'b1;
        end else if (first_lvl && flags.huge) begin
            fault = 1'b1;
            cause = CAUSE_HUGE;
        end else if (acc_user && !flags.user_ok) begin
            fault = 1'b1;
            cause = CAUSE_PRIV;
        end else if (acc_write && !flags.writable) begin
            fault = 1'b1;
            cause = CAUSE_WPROT;
        end
    end

endmodule

// File: rtl/ptw_entry_addr.sv
`timescale 1ns/1ps
module ptw_entry_addr #(
    parameter int PTE_W    = 32,
    parameter int OFF_BITS = 12,
    parameter int IDX_BITS = 10
) (
    input  logic [PTE_W-OFF_BITS-1:0] frame,
    input  logic [IDX_BITS-1:0]       idx,
    output logic [PTE_W-1:0]          addr
);

    localparam int ENT_SHIFT = $clog2(PTE_W / 8);

    logic [PTE_W-1:0] base;
    logic [PTE_W-1:0] disp;

    always_comb begin
        base = {frame, {OFF_BITS{1'b0}}};
        disp = PTE_W'(idx) << ENT_SHIFT;
        addr = base | disp;
    end

endmodule

// File: rtl/ptw_flag_update.sv
`timescale 1ns/1ps
module ptw_flag_update
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             mark_dirty,
    output logic [PTE_W-1:0] new_pte,
    output logic             changed
);

    always_comb begin
        new_pte          = pte;
        new_pte[BIT_ACC] = 1'b1;
        if (mark_dirty) begin
            new_pte[BIT_DIRTY] = 1'b1;
        end
        changed = (new_pte != pte);
    end

endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import ptw_pkg::*;
#(
    parameter int L1_BITS  = 10,
    parameter int L2_BITS  = 10,
    parameter int OFF_BITS = 12,
    parameter int PTE_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PTE_W-OFF_BITS-1:0] root_frame,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [L1_BITS+L2_BITS+OFF_BITS-1:0] req_vaddr,
    input  logic                      req_write,
    input  logic                      req_user,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic                      mem_req_we,
    output logic [PTE_W-1:0]          mem_req_addr,
    output logic [PTE_W-1:0]          mem_req_wdata,
    input  logic                      mem_rsp_valid,
    input  logic [PTE_W-1:0]          mem_rsp_rdata,
    output logic                      rsp_valid,
    output logic                      rsp_fault,
    output logic [1:0]                rsp_cause,
    output logic                      rsp_level,
    output logic [PTE_W-1:0]          rsp_paddr,
    output logic [L1_BITS+L2_BITS+OFF_BITS-1:0] rsp_vaddr
);

    localparam int VA_W    = L1_BITS + L2_BITS + OFF_BITS;
    localparam int FRAME_W = PTE_W - OFF_BITS;
    localparam int L2_LO   = OFF_BITS;
    localparam int L1_LO   = OFF_BITS + L2_BITS;
    localparam int NLVL    = 2;

    typedef struct packed {
        walk_st_e           st;
        logic [VA_W-1:0]    va;
        logic               wr;
        logic               usr;
        logic [FRAME_W-1:0] root;
        logic [PTE_W-1:0]   pte1;
        logic [PTE_W-1:0]   pte2;
        logic [PTE_W-1:0]   paddr;
        logic               fault;
        fault_cause_e       cause;
        logic               lvl;
    } walk_t;

    localparam walk_t WALK_RST = '{st: S_IDLE, cause: CAUSE_ABSENT, default: '0};

    walk_t q, d;

    // ---------------------------------------------------------------
    // entry addresses for both levels
    // ---------------------------------------------------------------
    logic [PTE_W-1:0] l1_addr;
    logic [PTE_W-1:0] l2_addr;

    ptw_entry_addr #(.PTE_W(PTE_W), .OFF_BITS(OFF_BITS), .IDX_BITS(L1_BITS)) u_addr_l1 (
        .frame (q.root),
        .idx   (q.va[L1_LO +: L1_BITS]),
        .addr  (l1_addr)
    );

    ptw_entry_addr #(.PTE_W(PTE_W), .OFF_BITS(OFF_BITS), .IDX_BITS(L2_BITS)) u_addr_l2 (
        .frame (q.pte1[PTE_W-1:OFF_BITS]),
        .idx   (q.va[L2_LO +: L2_BITS]),
        .addr  (l2_addr)
    );

    // ---------------------------------------------------------------
    // permission check of the entry being examined
    // ---------------------------------------------------------------
    logic [PTE_W-1:0] chk_pte;
    pte_flags_t       chk_flags;
    logic             chk_fault;
    fault_cause_e     chk_cause;

    always_comb begin
        chk_pte            = (q.st == S_L2_CK) ? q.pte2 : q.pte1;
        chk_flags.present  = chk_pte[BIT_PRESENT];
        chk_flags.writable = chk_pte[BIT_WRITE];
        chk_flags.user_ok  = chk_pte[BIT_USER];
        chk_flags.huge     = chk_pte[BIT_HUGE];
    end

    ptw_entry_check u_check (
        .flags     (chk_flags),
        .first_lvl (q.st == S_L1_CK),
        .acc_write (q.wr),
        .acc_user  (q.usr),
        .fault     (chk_fault),
        .cause     (chk_cause)
    );

    // ---------------------------------------------------------------
    // accessed / dirty updates, one per level
    // ---------------------------------------------------------------
    logic [PTE_W-1:0] lvl_pte  [NLVL];
    logic [PTE_W-1:0] lvl_new  [NLVL];
    logic             lvl_dirt [NLVL];
    logic [NLVL-1:0]  lvl_chg;

    always_comb begin
        lvl_pte[0]  = q.pte1;
        lvl_pte[1]  = q.pte2;
        lvl_dirt[0] = 1'b0;
        lvl_dirt[1] = q.wr;
    end

    for (genvar g = 0; g < NLVL; g++) begin : g_upd
        ptw_flag_update #(.PTE_W(PTE_W)) u_upd (
            .pte        (lvl_pte[g]),
            .mark_dirty (lvl_dirt[g]),
            .new_pte    (lvl_new[g]),
            .changed    (lvl_chg[g])
        );
    end

    // ---------------------------------------------------------------
    // next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.st    = S_L1_RD;
                    d.va    = req_vaddr;
                    d.wr    = req_write;
                    d.usr   = req_user;
                    d.root  = root_frame;
                    d.fault = 1'b0;
                    d.cause = CAUSE_ABSENT;
                    d.lvl   = 1'b0;
                    d.paddr = '0;
                end
            end
            S_L1_RD: if (mem_req_ready) d.st = S_L1_WT;
            S_L1_WT: begin
                if (mem_rsp_valid) begin
                    d.pte1 = mem_rsp_rdata;
                    d.st   = S_L1_CK;
                end
            end
            S_L1_CK: begin
                if (chk_fault) begin
                    d.fault = 1'b1;
                    d.cause = chk_cause;
                    d.lvl   = 1'b0;
                    d.st    = S_DONE;
                end else begin
                    d.st = S_L2_RD;
                end
            end
            S_L2_RD: if (mem_req_ready) d.st = S_L2_WT;
            S_L2_WT: begin
                if (mem_rsp_valid) begin
                    d.pte2 = mem_rsp_rdata;
                    d.st   = S_L2_CK;
                end
            end
            S_L2_CK: begin
                if (chk_fault) begin
                    d.fault = 1'b1;
                    d.cause = chk_cause;
                    d.lvl   = 1'b1;
                    d.st    = S_DONE;
                end else begin
                    d.paddr = {q.pte2[PTE_W-1:OFF_BITS], q.va[OFF_BITS-1:0]};
                    if (lvl_chg[0])      d.st = S_WB1;
                    else if (lvl_chg[1]) d.st = S_WB2;
                    else                 d.st = S_DONE;
                end
            end
            S_WB1: begin
                if (mem_req_ready) d.st = lvl_chg[1] ? S_WB2 : S_DONE;
            end
            S_WB2: if (mem_req_ready) d.st = S_DONE;
            S_DONE: d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= WALK_RST;
        else        q <= d;
    end

    // ---------------------------------------------------------------
    // outputs
    // ---------------------------------------------------------------
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = l1_addr;
        mem_req_wdata = '0;
        unique case (q.st)
            S_L1_RD: mem_req_valid = 1'b1;
            S_L2_RD: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = l2_addr;
            end
            S_WB1: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_wdata = lvl_new[0];
            end
            S_WB2: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = l2_addr;
                mem_req_wdata = lvl_new[1];
            end
            default: ;
        endcase
    end

    assign req_ready = (q.st == S_IDLE);
    assign rsp_valid = (q.st == S_DONE);
    assign rsp_fault = q.fault;
    assign rsp_cause = q.cause;
    assign rsp_level = q.lvl;
    assign rsp_paddr = q.paddr;
    assign rsp_vaddr = q.va;

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_mem_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata));

    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_paddr[OFF_BITS-1:0] == rsp_vaddr[OFF_BITS-1:0]);

    assert_huge_first_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault && rsp_cause == 2'd3 |-> !rsp_level);

    assert_writeback_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_wdata[BIT_ACC] && mem_req_wdata[BIT_PRESENT]);

    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_frame = 20'h00010;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic        rsp_level;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_vaddr;

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk, .rst_n, .root_frame,
        .req_valid, .req_ready, .req_vaddr, .req_write, .req_user,
        .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
        .mem_rsp_valid, .mem_rsp_rdata,
        .rsp_valid, .rsp_fault, .rsp_cause, .rsp_level, .rsp_paddr, .rsp_vaddr
    );

    // ------------------------------------------------------------ memory
    logic [31:0] mem [bit [31:0]];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] rd_log [8];
    bit          stall = 1'b0;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rsp_rdata <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
                mem_rsp_valid <= 1'b1;
                rd_log[rd_cnt % 8] = mem_req_addr;
                rd_cnt = rd_cnt + 1;
            end
        end
    end

    always @(negedge clk) mem_req_ready <= stall ? ~mem_req_ready : 1'b1;

    // ------------------------------------------------------------ checks
    int total = 0;
    int bad   = 0;

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // results of the last walk
    logic        r_fault, r_level, r_busy, r_after;
    logic [1:0]  r_cause;
    logic [31:0] r_paddr, r_vaddr, r_rd0, r_rd1;
    int          n_rd, n_wr;

    task automatic xlate(input logic [31:0] va, input bit wr, input bit usr);
        int rb, wb, guard;
        logic [19:0] keep_root;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rb = rd_cnt;
        wb = wr_cnt;
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        r_busy     = req_ready;
        keep_root  = root_frame;
        root_frame = 20'hDEADF;   // must not disturb the walk already taken
        req_vaddr  = 32'h0BAD_0BAD;
        req_write  = ~wr;
        req_user   = ~usr;
        guard = 0;
        while (!rsp_valid && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        if (!rsp_valid) check("R11", "walk timeout", 32'd0, 32'd1);
        r_fault = rsp_fault; r_cause = rsp_cause; r_level = rsp_level;
        r_paddr = rsp_paddr; r_vaddr = rsp_vaddr;
        @(negedge clk);
        r_after = rsp_valid;
        root_frame = keep_root;
        n_rd  = rd_cnt - rb;
        n_wr  = wr_cnt - wb;
        r_rd0 = rd_log[rb % 8];
        r_rd1 = rd_log[(rb + 1) % 8];
        check("R1", "ready while busy", {31'd0, r_busy}, 32'd0);
        check("R11", "pulse length", {31'd0, r_after}, 32'd0);
        check("R11", "vaddr echo", r_vaddr, va);
    endtask

    task automatic expect_ok(input string rq, input logic [31:0] pa);
        check(rq, "fault flag", {31'd0, r_fault}, 32'd0);
        check(rq, "paddr", r_paddr, pa);
    endtask

    task automatic expect_fault(input string rq, input logic [1:0] cause, input logic lvl);
        check(rq, "fault flag", {31'd0, r_fault}, 32'd1);
        check(rq, "cause", {30'd0, r_cause}, {30'd0, cause});
        check(rq, "level", {31'd0, r_level}, {31'd0, lvl});
        check("R10", "no write on fault", n_wr, 0);
    endtask

    // ------------------------------------------------------------ scenarios
    task automatic t_reset();
        check("R1", "ready in reset", {31'd0, req_ready}, 32'd1);
        check("R11", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R4", "mem req in reset", {31'd0, mem_req_valid}, 32'd0);
    endtask

    task automatic t_basic_walk();
        mem[32'h0001_000C] = 32'h0002_0007;
        mem[32'h0002_0014] = 32'hABCD_E007;
        xlate(32'h00C0_5123, 1'b0, 1'b0);
        expect_ok("R5", 32'hABCD_E123);
        check("R4", "read count", n_rd, 2);
        check("R2", "l1 entry addr", r_rd0, 32'h0001_000C);
        check("R3", "l2 entry addr", r_rd1, 32'h0002_0014);
        check("R10", "write count", n_wr, 2);
        check("R10", "l1 accessed", peek(32'h0001_000C), 32'h0002_0027);
        check("R10", "l2 accessed", peek(32'h0002_0014), 32'hABCD_E027);
        xlate(32'h00C0_5123, 1'b0, 1'b0);
        expect_ok("R5", 32'hABCD_E123);
        check("R10", "no write when unchanged", n_wr, 0);
    endtask

    task automatic t_dirty();
        xlate(32'h00C0_5ABC, 1'b1, 1'b1);
        expect_ok("R5", 32'hABCD_EABC);
        check("R10", "dirty write count", n_wr, 1);
        check("R10", "l2 dirty", peek(32'h0002_0014), 32'hABCD_E067);
        check("R10", "l1 kept", peek(32'h0001_000C), 32'h0002_0027);
        xlate(32'h00C0_5001, 1'b1, 1'b0);
        check("R10", "dirty already set", n_wr, 0);
    endtask

    task automatic t_absent();
        mem[32'h0001_001C] = 32'hFFFF_FFFE;
        xlate(32'h01C0_0456, 1'b1, 1'b1);
        expect_fault("R6", 2'd0, 1'b0);
        check("R6", "single read", n_rd, 1);
        check("R6", "entry untouched", peek(32'h0001_001C), 32'hFFFF_FFFE);
        mem[32'h0001_0020] = 32'h0003_0007;
        mem[32'h0003_0000] = 32'hFFFF_FFFE;
        xlate(32'h0200_0010, 1'b0, 1'b0);
        expect_fault("R6", 2'd0, 1'b1);
        check("R4", "two reads", n_rd, 2);
    endtask

    task automatic t_huge();
        mem[32'h0001_0024] = 32'h0004_0087;
        xlate(32'h0240_0000, 1'b0, 1'b0);
        expect_fault("R7", 2'd3, 1'b0);
        check("R7", "single read", n_rd, 1);
        mem[32'h0001_0038] = 32'h0000_0080;
        xlate(32'h0380_0000, 1'b0, 1'b0);
        expect_fault("R9", 2'd0, 1'b0);   // absent outranks large page
        mem[32'h0003_0004] = 32'h5555_5087;
        xlate(32'h0200_102A, 1'b0, 1'b0);
        expect_ok("R7", 32'h5555_502A);
    endtask

    task automatic t_priv();
        mem[32'h0001_0028] = 32'h0005_0003;
        mem[32'h0005_0000] = 32'h6666_6003;
        xlate(32'h0280_0111, 1'b0, 1'b1);
        expect_fault("R8", 2'd2, 1'b0);
        xlate(32'h0280_0111, 1'b0, 1'b0);
        expect_ok("R8", 32'h6666_6111);
        mem[32'h0001_002C] = 32'h0006_0007;
        mem[32'h0006_0000] = 32'h7777_7003;
        xlate(32'h02C0_0222, 1'b0, 1'b1);
        expect_fault("R8", 2'd2, 1'b1);
    endtask

    task automatic t_wprot();
        mem[32'h0001_0030] = 32'h0007_0005;
        mem[32'h0007_0000] = 32'hAAAA_A007;
        xlate(32'h0300_0333, 1'b1, 1'b1);
        expect_fault("R9", 2'd1, 1'b0);
        xlate(32'h0300_0333, 1'b0, 1'b1);
        expect_ok("R9", 32'hAAAA_A333);
        mem[32'h0001_0034] = 32'h0008_0007;
        mem[32'h0008_0000] = 32'h8888_8005;
        xlate(32'h0340_0444, 1'b1, 1'b0);
        expect_fault("R9", 2'd1, 1'b1);
        check("R9", "leaf untouched", peek(32'h0008_0000), 32'h8888_8005);
        mem[32'h0008_0004] = 32'h9999_9001;
        xlate(32'h0340_1555, 1'b1, 1'b1);
        expect_fault("R9", 2'd2, 1'b1);   // privilege outranks write protect
    endtask

    task automatic t_stall_edge();
        stall = 1'b1;
        mem[32'h0001_0FFC] = 32'h0009_0007;
        mem[32'h0009_0FFC] = 32'hCAFE_B007;
        xlate(32'hFFFF_FFFF, 1'b1, 1'b1);
        expect_ok("R5", 32'hCAFE_BFFF);
        check("R4", "reads under stall", n_rd, 2);
        check("R2", "last l1 slot", r_rd0, 32'h0001_0FFC);
        check("R3", "last l2 slot", r_rd1, 32'h0009_0FFC);
        check("R10", "writes under stall", n_wr, 2);
        check("R10", "l1 after stall", peek(32'h0001_0FFC), 32'h0009_0027);
        check("R10", "l2 after stall", peek(32'h0009_0FFC), 32'hCAFE_B067);
        stall = 1'b0;
    endtask

    task automatic t_switch_root();
        root_frame = 20'h0000B;
        mem[32'h0000_B00C] = 32'h000C_0007;
        mem[32'h000C_0014] = 32'h1234_5007;
        xlate(32'h00C0_5123, 1'b0, 1'b0);
        expect_ok("R2", 32'h1234_5123);
        check("R2", "new root l1 addr", r_rd0, 32'h0000_B00C);
        root_frame = 20'h00010;
    endtask

    // ------------------------------------------------------------ run
    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic_walk();
        t_dirty();
        t_absent();
        t_huge();
        t_priv();
        t_wprot();
        t_stall_edge();
        t_switch_root();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule